// File: doc/BRIEF.md
# Operand Addressing Mode Decoder

This block turns the addressing fields of one instruction operand into a compact operand descriptor. The caller gives a register number together with either a two-bit source mode or a one-bit destination mode. The block reports what kind of operand it is, which register it names and a 20-bit addend. Two registers have special meanings. The status register and the constant register act as a constant generator, so several mode and register pairs stand for small immediates and need no memory word. The program counter in indexed or post-increment mode turns into a PC-relative symbolic address or an inline immediate.

When the mode needs an extension word, the block asks an upstream word-fetch port for it. It holds that request until the port acknowledges, then builds the addend from the returned word. An optional four-bit high part can be placed above the word to widen the addend to 20 bits. For a symbolic operand, the caller also supplies the instruction address and the byte offset of the extension word inside the instruction. The result appears as a one-cycle `op_valid` pulse. Operand kind codes on `op_kind` are: 0 register, 1 immediate, 2 indexed indirect (register plus addend), 3 absolute address, 4 indirect with post-increment. Register numbers with a special role are 0 (program counter), 2 (status register) and 3 (constant register).

Top module: `opnd_mode_decoder`

## Requirements
- R1: Source mode 0: register 3 gives kind 1 with addend 0 and `op_reg` 0; any other register gives kind 0 with `op_reg` equal to that register and addend 0. No fetch is made.
- R2: Source mode 1 with register 0 fetches a word and gives kind 3 with `op_reg` 0. The addend is the widened word plus `instr_pc` plus `word_ofs`, taken modulo 2^20.
- R3: Source mode 1: register 2 fetches and gives kind 3 with the widened word as addend. Register 3 gives kind 1 with addend 1 and no fetch. Any other register fetches and gives kind 2 with that register and the widened word.
- R4: Source mode 2: register 2 gives kind 1 with addend 4, and register 3 gives kind 1 with addend 2. Any other register gives kind 2 with that register and addend 0. No fetch is made.
- R5: Source mode 3: register 0 fetches and gives kind 1 with the widened word. Register 2 gives kind 1 with addend 8. Register 3 gives kind 1 with addend 0xFFFFF. Any other register gives kind 4 with that register and addend 0.
- R6: In destination decoding only `mode[0]` counts. A value of 0 gives kind 0 for every register, with no fetch. A value of 1 fetches: register 0 gives a symbolic kind 3 as in R2, register 2 gives kind 3 with the widened word, and any other register gives kind 2.
- R7: The widened word is `{ext_hi, fetch_word}` when `ext_valid` is 1 and `{4'h0, fetch_word}` when it is 0.
- R8: `fetch_req` rises in the cycle after an accepted `start` for a fetching mode. It stays high until a cycle with `fetch_ack` high and falls in the cycle after that one.
- R9: `op_valid` is high for exactly one cycle. That cycle follows the `fetch_ack` cycle for fetching modes, and follows the `start` cycle otherwise. `fetch_req` and `op_valid` are never high together.
- R10: The constant-generator pairs (source mode 0/1 with register 3, source mode 2/3 with register 2 or 3) never raise `fetch_req`.
- R11: A `start` that arrives while a decode is in progress, including its `op_valid` cycle, is ignored and does not change the result.
- R12: While `rst_n` is low, `fetch_req` and `op_valid` are 0. Reset acts at once, even in the middle of a fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin decoding the operand fields presented this cycle |
| is_dst | input | 1 | 1 selects destination decoding, 0 source decoding |
| mode | input | 2 | Addressing mode field (only bit 0 used for destinations) |
| reg_num | input | 4 | Register number field |
| ext_valid | input | 1 | High-address extension present |
| ext_hi | input | 4 | High-address extension bits |
| instr_pc | input | 20 | Address of the instruction |
| word_ofs | input | 8 | Byte offset of the extension word within the instruction |
| fetch_req | output | 1 | Request for the next 16-bit extension word |
| fetch_ack | input | 1 | Fetch port returns the word this cycle |
| fetch_word | input | 16 | Returned extension word |
| op_valid | output | 1 | One-cycle descriptor strobe |
| op_kind | output | 3 | Operand kind code |
| op_reg | output | 4 | Register number of the operand |
| op_addend | output | 20 | Constant, address or index |

## Verification
The hardest case to reach from the ports is a new `start` that arrives while the block is still busy. Two moments matter: while the fetch request is waiting for an acknowledge, and during the single strobe cycle. In both, the new fields must not leak into the result or launch a second decode. The stimulus holds the acknowledge back for several cycles and raises `start` with different register-mode fields during that wait. It then raises `start` again in the strobe cycle and watches that neither a second strobe nor a fetch follows. Symbolic addends that wrap past 2^20 and an `ext_hi` that is present but not flagged valid are driven as directed cases.

// File: rtl/opd_pkg.sv
package opd_pkg;

  typedef enum logic [2:0] {
    OPK_REG  = 3'd0,
    OPK_IMM  = 3'd1,
    OPK_IDX  = 3'd2,
    OPK_ABS  = 3'd3,
    OPK_PINC = 3'd4
  } opk_e;

  typedef enum logic [1:0] {
    ASEL_ZERO,
    ASEL_CONST,
    ASEL_WORD,
    ASEL_SYM
  } asel_e;

  typedef enum logic [2:0] {
    CG_ZERO,
    CG_ONE,
    CG_TWO,
    CG_FOUR,
    CG_EIGHT,
    CG_ALL1
  } cg_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_DONE
  } st_e;

  localparam int unsigned PC_REG = 0;
  localparam int unsigned SR_REG = 2;
  localparam int unsigned CG_REG = 3;

  typedef struct packed {
    opk_e  kind;
    asel_e asel;
    cg_e   cg;
    logic  need_fetch;
    logic  keep_reg;
  } cls_t;

endpackage

// File: rtl/opd_classify.sv
module opd_classify
  import opd_pkg::*;
#(
  parameter int unsigned REG_W = 4
) (
  input  logic             is_dst,
  input  logic [1:0]       mode,
  input  logic [REG_W-1:0] reg_num,
  output cls_t             cls
);

  localparam logic [REG_W-1:0] R_PC = REG_W'(PC_REG);
  localparam logic [REG_W-1:0] R_SR = REG_W'(SR_REG);
  localparam logic [REG_W-1:0] R_CG = REG_W'(CG_REG);

  logic is_pc, is_sr, is_cg;

  assign is_pc = (reg_num == R_PC);
  assign is_sr = (reg_num == R_SR);
  assign is_cg = (reg_num == R_CG);

  always_comb begin
    cls.kind       = OPK_REG;
    cls.asel       = ASEL_ZERO;
    cls.cg         = CG_ZERO;
    cls.need_fetch = 1'b0;
    cls.keep_reg   = 1'b1;
    if (is_dst) begin
      if (mode[0]) begin
        cls.need_fetch = 1'b1;
        if (is_pc) begin
          cls.kind     = OPK_ABS;
          cls.asel     = ASEL_SYM;
          cls.keep_reg = 1'b0;
        end else if (is_sr) begin
          cls.kind     = OPK_ABS;
          cls.asel     = ASEL_WORD;
          cls.keep_reg = 1'b0;
        end else begin
          cls.kind = OPK_IDX;
          cls.asel = ASEL_WORD;
        end
      end
    end else begin
      unique case (mode)
        2'b00: begin
          if (is_cg) begin
            cls.kind     = OPK_IMM;
            cls.asel     = ASEL_CONST;
            cls.cg       = CG_ZERO;
            cls.keep_reg = 1'b0;
          end
        end
        2'b01: begin
          if (is_cg) begin
            cls.kind     = OPK_IMM;
            cls.asel     = ASEL_CONST;
            cls.cg       = CG_ONE;
            cls.keep_reg = 1'b0;
          end else begin
            cls.need_fetch = 1'b1;
            if (is_pc) begin
              cls.kind     = OPK_ABS;
              cls.asel     = ASEL_SYM;
              cls.keep_reg = 1'b0;
            end else if (is_sr) begin
              cls.kind     = OPK_ABS;
              cls.asel     = ASEL_WORD;
              cls.keep_reg = 1'b0;
            end else begin
              cls.kind = OPK_IDX;
              cls.asel = ASEL_WORD;
            end
          end
        end
        2'b10: begin
          if (is_sr || is_cg) begin
            cls.kind     = OPK_IMM;
            cls.asel     = ASEL_CONST;
            cls.cg       = is_sr ? CG_FOUR : CG_TWO;
            cls.keep_reg = 1'b0;
          end else begin
            cls.kind = OPK_IDX;
          end
        end
        default: begin
          if (is_pc) begin
            cls.kind       = OPK_IMM;
            cls.asel       = ASEL_WORD;
            cls.need_fetch = 1'b1;
            cls.keep_reg   = 1'b0;
          end else if (is_sr || is_cg) begin
            cls.kind     = OPK_IMM;
            cls.asel     = ASEL_CONST;
            cls.cg       = is_sr ? CG_EIGHT : CG_ALL1;
            cls.keep_reg = 1'b0;
          end else begin
            cls.kind = OPK_PINC;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/opd_addend.sv
module opd_addend
  import opd_pkg::*;
#(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned EXT_W  = 4,
  parameter int unsigned OFS_W  = 8
) (
  input  asel_e                    asel,
  input  cg_e                      cg,
  input  logic                     ext_valid,
  input  logic [EXT_W-1:0]         ext_hi,
  input  logic [WORD_W-1:0]        word,
  input  logic [WORD_W+EXT_W-1:0]  pc,
  input  logic [OFS_W-1:0]         ofs,
  output logic [WORD_W+EXT_W-1:0]  addend
);

  localparam int unsigned ADDR_W = WORD_W + EXT_W;

  logic [EXT_W-1:0]  hi_part;
  logic [ADDR_W-1:0] wide_word;
  logic [ADDR_W-1:0] sym_addr;
  logic [ADDR_W-1:0] cg_val;

  assign hi_part   = ext_valid ? ext_hi : '0;
  assign wide_word = {hi_part, word};
  assign sym_addr  = wide_word + pc + ADDR_W'(ofs);

  always_comb begin
    unique case (cg)
      CG_ONE:   cg_val = ADDR_W'(1);
      CG_TWO:   cg_val = ADDR_W'(2);
      CG_FOUR:  cg_val = ADDR_W'(4);
      CG_EIGHT: cg_val = ADDR_W'(8);
      CG_ALL1:  cg_val = '1;
      default:  cg_val = '0;
    endcase
  end

  always_comb begin
    unique case (asel)
      ASEL_CONST: addend = cg_val;
      ASEL_WORD:  addend = wide_word;
      ASEL_SYM:   addend = sym_addr;
      default:    addend = '0;
    endcase
  end

endmodule

// File: rtl/opd_ctrl.sv
module opd_ctrl
  import opd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic need_fetch,
  input  logic fetch_ack,
  output logic fetch_req,
  output logic op_valid,
  output logic idle,
  output logic load_req,
  output logic load_desc
);

  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start) st_d = need_fetch ? ST_FETCH : ST_DONE;
      ST_FETCH: if (fetch_ack) st_d = ST_DONE;
      ST_DONE:  st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign idle      = (st_q == ST_IDLE);
  assign fetch_req = (st_q == ST_FETCH);
  assign op_valid  = (st_q == ST_DONE);
  assign load_req  = idle && start;
  assign load_desc = (load_req && !need_fetch) || (fetch_req && fetch_ack);

endmodule

// File: rtl/opnd_mode_decoder.sv
module opnd_mode_decoder
  import opd_pkg::*;
#(
  parameter int unsigned WORD_W      = 16,
  parameter int unsigned EXT_W       = 4,
  parameter int unsigned REG_W       = 4,
  parameter int unsigned OFS_W       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    is_dst,
  input  logic [1:0]              mode,
  input  logic [REG_W-1:0]        reg_num,
  input  logic                    ext_valid,
  input  logic [EXT_W-1:0]        ext_hi,
  input  logic [WORD_W+EXT_W-1:0] instr_pc,
  input  logic [OFS_W-1:0]        word_ofs,
  output logic                    fetch_req,
  input  logic                    fetch_ack,
  input  logic [WORD_W-1:0]       fetch_word,
  output logic                    op_valid,
  output logic [2:0]              op_kind,
  output logic [REG_W-1:0]        op_reg,
  output logic [WORD_W+EXT_W-1:0] op_addend
);

  localparam int unsigned ADDR_W = WORD_W + EXT_W;

  // reset: asserted at once, released through a synchronizer
  logic rst_n_sync;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic rs_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= 1'b0;
        else        rs_q <= 1'b1;
      end
      assign rst_n_sync = rs_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] rs_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_n_sync = rs_q[SYNC_STAGES-1];
    end
  endgenerate

  // control
  logic ctl_idle, load_req, load_desc;
  cls_t cls;

  opd_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .start      (start),
    .need_fetch (cls.need_fetch),
    .fetch_ack  (fetch_ack),
    .fetch_req  (fetch_req),
    .op_valid   (op_valid),
    .idle       (ctl_idle),
    .load_req   (load_req),
    .load_desc  (load_desc)
  );

  // captured request fields
  logic              h_dst_q, h_dst_d;
  logic [1:0]        h_mode_q, h_mode_d;
  logic [REG_W-1:0]  h_reg_q, h_reg_d;
  logic              h_extv_q, h_extv_d;
  logic [EXT_W-1:0]  h_ext_q, h_ext_d;
  logic [ADDR_W-1:0] h_pc_q, h_pc_d;
  logic [OFS_W-1:0]  h_ofs_q, h_ofs_d;

  always_comb begin
    h_dst_d  = h_dst_q;
    h_mode_d = h_mode_q;
    h_reg_d  = h_reg_q;
    h_extv_d = h_extv_q;
    h_ext_d  = h_ext_q;
    h_pc_d   = h_pc_q;
    h_ofs_d  = h_ofs_q;
    if (load_req) begin
      h_dst_d  = is_dst;
      h_mode_d = mode;
      h_reg_d  = reg_num;
      h_extv_d = ext_valid;
      h_ext_d  = ext_hi;
      h_pc_d   = instr_pc;
      h_ofs_d  = word_ofs;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      h_dst_q  <= 1'b0;
      h_mode_q <= '0;
      h_reg_q  <= '0;
      h_extv_q <= 1'b0;
      h_ext_q  <= '0;
      h_pc_q   <= '0;
      h_ofs_q  <= '0;
    end else begin
      h_dst_q  <= h_dst_d;
      h_mode_q <= h_mode_d;
      h_reg_q  <= h_reg_d;
      h_extv_q <= h_extv_d;
      h_ext_q  <= h_ext_d;
      h_pc_q   <= h_pc_d;
      h_ofs_q  <= h_ofs_d;
    end
  end

  // live fields while idle, captured fields while busy
  logic              s_dst, s_extv;
  logic [1:0]        s_mode;
  logic [REG_W-1:0]  s_reg;
  logic [EXT_W-1:0]  s_ext;
  logic [ADDR_W-1:0] s_pc;
  logic [OFS_W-1:0]  s_ofs;

  assign s_dst  = ctl_idle ? is_dst    : h_dst_q;
  assign s_mode = ctl_idle ? mode      : h_mode_q;
  assign s_reg  = ctl_idle ? reg_num   : h_reg_q;
  assign s_extv = ctl_idle ? ext_valid : h_extv_q;
  assign s_ext  = ctl_idle ? ext_hi    : h_ext_q;
  assign s_pc   = ctl_idle ? instr_pc  : h_pc_q;
  assign s_ofs  = ctl_idle ? word_ofs  : h_ofs_q;

  opd_classify #(.REG_W(REG_W)) u_cls (
    .is_dst  (s_dst),
    .mode    (s_mode),
    .reg_num (s_reg),
    .cls     (cls)
  );

  logic [ADDR_W-1:0] addend_w;

  opd_addend #(.WORD_W(WORD_W), .EXT_W(EXT_W), .OFS_W(OFS_W)) u_add (
    .asel      (cls.asel),
    .cg        (cls.cg),
    .ext_valid (s_extv),
    .ext_hi    (s_ext),
    .word      (fetch_word),
    .pc        (s_pc),
    .ofs       (s_ofs),
    .addend    (addend_w)
  );

  // descriptor registers
  logic [2:0]        kind_q, kind_d;
  logic [REG_W-1:0]  oreg_q, oreg_d;
  logic [ADDR_W-1:0] add_q, add_d;

  always_comb begin
    kind_d = kind_q;
    oreg_d = oreg_q;
    add_d  = add_q;
    if (load_desc) begin
      kind_d = cls.kind;
      oreg_d = cls.keep_reg ? s_reg : '0;
      add_d  = addend_w;
    end
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      kind_q <= '0;
      oreg_q <= '0;
      add_q  <= '0;
    end else begin
      kind_q <= kind_d;
      oreg_q <= oreg_d;
      add_q  <= add_d;
    end
  end

  assign op_kind   = kind_q;
  assign op_reg    = oreg_q;
  assign op_addend = add_q;

endmodule

// File: rtl/opnd_mode_decoder_chk.sv
module opnd_mode_decoder_chk #(
  parameter int unsigned REG_W = 4
) (
  input logic             clk,
  input logic             rst_ok,
  input logic             idle,
  input logic             start,
  input logic             is_dst,
  input logic [1:0]       mode,
  input logic [REG_W-1:0] reg_num,
  input logic             fetch_req,
  input logic             fetch_ack,
  input logic             op_valid,
  input logic [2:0]       op_kind,
  input logic [REG_W-1:0] op_reg
);

  logic accept, cg_hit, plain_reg, sym_src;

  assign accept    = start && idle;
  assign cg_hit    = !is_dst && ((reg_num == REG_W'(3)) ||
                                 (mode[1] && reg_num == REG_W'(2)));
  assign plain_reg = !is_dst && (mode == 2'b00) && (reg_num != REG_W'(3));
  assign sym_src   = !is_dst && (mode == 2'b01) && (reg_num == '0);

  // R8
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    fetch_req && !fetch_ack |=> fetch_req);

  // R8
  fetch_drop_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    fetch_req && fetch_ack |=> !fetch_req && op_valid);

  // R9
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    op_valid |=> !op_valid);

  // R9
  valid_excl_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    !(op_valid && fetch_req));

  // R10
  cg_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    accept && cg_hit |=> op_valid && !fetch_req);

  // R1
  reg_mode_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    accept && plain_reg |=> op_valid && op_kind == 3'd0 && op_reg == $past(reg_num));

  // R2
  sym_fetch_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    accept && sym_src |=> fetch_req && !op_valid);

endmodule

bind opnd_mode_decoder opnd_mode_decoder_chk #(.REG_W(REG_W)) u_chk (
  .clk       (clk),
  .rst_ok    (rst_n_sync),
  .idle      (ctl_idle),
  .start     (start),
  .is_dst    (is_dst),
  .mode      (mode),
  .reg_num   (reg_num),
  .fetch_req (fetch_req),
  .fetch_ack (fetch_ack),
  .op_valid  (op_valid),
  .op_kind   (op_kind),
  .op_reg    (op_reg)
);

// File: tb/opnd_mode_decoder_test.sv
module opnd_mode_decoder_test;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        is_dst;
  logic [1:0]  mode;
  logic [3:0]  reg_num;
  logic        ext_valid;
  logic [3:0]  ext_hi;
  logic [19:0] instr_pc;
  logic [7:0]  word_ofs;
  logic        fetch_req;
  logic        fetch_ack;
  logic [15:0] fetch_word;
  logic        op_valid;
  logic [2:0]  op_kind;
  logic [3:0]  op_reg;
  logic [19:0] op_addend;

  opnd_mode_decoder uut (
    .clk(clk), .rst_n(rst_n), .start(start), .is_dst(is_dst), .mode(mode),
    .reg_num(reg_num), .ext_valid(ext_valid), .ext_hi(ext_hi),
    .instr_pc(instr_pc), .word_ofs(word_ofs), .fetch_req(fetch_req),
    .fetch_ack(fetch_ack), .fetch_word(fetch_word), .op_valid(op_valid),
    .op_kind(op_kind), .op_reg(op_reg), .op_addend(op_addend)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done_flag = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // vector: dst mode reg extv ext word | efetch ekind ereg eadd
  function automatic logic [55:0] mk(input logic d, input logic [1:0] m,
      input logic [3:0] r, input logic xv, input logic [3:0] x,
      input logic [15:0] w, input logic ef, input logic [2:0] ek,
      input logic [3:0] er, input logic [19:0] ea);
    return {d, m, r, xv, x, w, ef, ek, er, ea};
  endfunction

  localparam int NV = 21;
  localparam logic [55:0] VEC [NV] = '{
    mk(0, 2'd0, 4'd5,  0, 4'h0, 16'h0000, 0, 3'd0, 4'd5,  20'h00000), // R1
    mk(0, 2'd0, 4'd3,  0, 4'h0, 16'h0000, 0, 3'd1, 4'd0,  20'h00000), // R1
    mk(0, 2'd0, 4'd0,  0, 4'h0, 16'h0000, 0, 3'd0, 4'd0,  20'h00000), // R1
    mk(0, 2'd1, 4'd0,  0, 4'h0, 16'h0010, 1, 3'd3, 4'd0,  20'h0F012), // R2
    mk(0, 2'd1, 4'd0,  1, 4'h2, 16'h1234, 1, 3'd3, 4'd0,  20'h30236), // R2 R7
    mk(0, 2'd1, 4'd2,  0, 4'h0, 16'hBEEF, 1, 3'd3, 4'd0,  20'h0BEEF), // R3
    mk(0, 2'd1, 4'd3,  0, 4'h0, 16'h0000, 0, 3'd1, 4'd0,  20'h00001), // R3
    mk(0, 2'd1, 4'd7,  1, 4'h5, 16'h0042, 1, 3'd2, 4'd7,  20'h50042), // R3 R7
    mk(0, 2'd2, 4'd2,  0, 4'h0, 16'h0000, 0, 3'd1, 4'd0,  20'h00004), // R4
    mk(0, 2'd2, 4'd3,  0, 4'h0, 16'h0000, 0, 3'd1, 4'd0,  20'h00002), // R4
    mk(0, 2'd2, 4'd9,  0, 4'h0, 16'h0000, 0, 3'd2, 4'd9,  20'h00000), // R4
    mk(0, 2'd3, 4'd0,  1, 4'hF, 16'hABCD, 1, 3'd1, 4'd0,  20'hFABCD), // R5
    mk(0, 2'd3, 4'd2,  0, 4'h0, 16'h0000, 0, 3'd1, 4'd0,  20'h00008), // R5
    mk(0, 2'd3, 4'd3,  0, 4'h0, 16'h0000, 0, 3'd1, 4'd0,  20'hFFFFF), // R5
    mk(0, 2'd3, 4'd12, 0, 4'h0, 16'h0000, 0, 3'd4, 4'd12, 20'h00000), // R5
    mk(1, 2'd0, 4'd6,  0, 4'h0, 16'h0000, 0, 3'd0, 4'd6,  20'h00000), // R6
    mk(1, 2'd2, 4'd3,  0, 4'h0, 16'h0000, 0, 3'd0, 4'd3,  20'h00000), // R6
    mk(1, 2'd1, 4'd0,  0, 4'h0, 16'h0100, 1, 3'd3, 4'd0,  20'h0F102), // R6
    mk(1, 2'd3, 4'd2,  0, 4'h0, 16'h0200, 1, 3'd3, 4'd0,  20'h00200), // R6
    mk(1, 2'd1, 4'd3,  1, 4'h1, 16'h0300, 1, 3'd2, 4'd3,  20'h10300), // R6 R7
    mk(0, 2'd1, 4'd8,  0, 4'hA, 16'h7777, 1, 3'd2, 4'd8,  20'h07777)  // R7
  };

  logic        got_fetch, held_ok, pulse_ok, quiet_ok;
  logic [2:0]  got_kind;
  logic [3:0]  got_reg;
  logic [19:0] got_add;
  int          got_lat;

  task automatic do_op(input logic d, input logic [1:0] m, input logic [3:0] r,
                       input logic xv, input logic [3:0] x, input logic [15:0] w,
                       input logic [19:0] pc, input logic [7:0] ofs,
                       input int ack_dly, input bit poke_busy, input bit poke_done);
    int waitn;
    @(negedge clk);
    start = 1; is_dst = d; mode = m; reg_num = r; ext_valid = xv; ext_hi = x;
    instr_pc = pc; word_ofs = ofs;
    @(negedge clk);
    start = 0;
    got_lat = 1; got_fetch = 0; held_ok = 1; waitn = 0;
    while (!op_valid && got_lat < 60) begin
      if (fetch_req) begin
        got_fetch = 1;
        if (poke_busy && waitn == 0) begin
          start = 1; is_dst = 0; mode = 2'd0; reg_num = 4'd5; ext_valid = 1; ext_hi = 4'h6;
        end
        if (waitn >= ack_dly) begin
          fetch_ack = 1; fetch_word = w;
        end
        waitn++;
      end else if (got_fetch) begin
        held_ok = 0;
      end
      @(negedge clk);
      start = 0; fetch_ack = 0; fetch_word = 16'hDEAD;
      got_lat++;
    end
    got_kind = op_kind; got_reg = op_reg; got_add = op_addend;
    if (poke_done) begin
      start = 1; is_dst = 0; mode = 2'd0; reg_num = 4'd1;
    end
    @(negedge clk);
    start = 0;
    pulse_ok = !op_valid;
    quiet_ok = !op_valid && !fetch_req;
    @(negedge clk);
    quiet_ok = quiet_ok && !op_valid && !fetch_req;
  endtask

  initial begin
    rst_n = 0; start = 0; is_dst = 0; mode = 0; reg_num = 0; ext_valid = 0;
    ext_hi = 0; instr_pc = 0; word_ofs = 0; fetch_ack = 0; fetch_word = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(fetch_req == 0, "R12", "fetch_req in reset", fetch_req, 0);
    chk(op_valid == 0, "R12", "op_valid in reset", op_valid, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [55:0] v;
      int exp_lat;
      v = VEC[i];
      do_op(v[55], v[54:53], v[52:49], v[48], v[47:44], v[43:28],
            20'h0F000, 8'd2, 0, 0, 0);
      exp_lat = v[27] ? 2 : 1;
      chk(got_fetch == v[27], "R10", $sformatf("vec %0d fetch", i), got_fetch, v[27]);
      chk(got_kind == v[26:24], "R1-6", $sformatf("vec %0d kind", i), got_kind, v[26:24]);
      chk(got_reg == v[23:20], "R1-6", $sformatf("vec %0d reg", i), got_reg, v[23:20]);
      chk(got_add == v[19:0], "R7", $sformatf("vec %0d addend", i), got_add, v[19:0]);
      chk(got_lat == exp_lat, "R9", $sformatf("vec %0d latency", i), got_lat, exp_lat);
      chk(pulse_ok, "R9", $sformatf("vec %0d single pulse", i), pulse_ok, 1);
    end

    // R2 symbolic wrap past 2^20
    do_op(0, 2'd1, 4'd0, 0, 4'h0, 16'h0020, 20'hFFFF0, 8'd4, 0, 0, 0);
    chk(got_kind == 3'd3, "R2", "wrap kind", got_kind, 3);
    chk(got_add == 20'h00014, "R2", "wrap addend", got_add, 20'h00014);

    // R8 acknowledge held back five cycles
    do_op(1, 2'd1, 4'd10, 1, 4'h3, 16'h4444, 20'h0, 8'd2, 5, 0, 0);
    chk(held_ok, "R8", "request held until ack", held_ok, 1);
    chk(got_lat == 7, "R8", "delayed ack latency", got_lat, 7);
    chk(got_add == 20'h34444, "R8", "delayed ack addend", got_add, 20'h34444);
    chk(pulse_ok, "R9", "delayed ack single pulse", pulse_ok, 1);

    // R11 start during the fetch wait and during the strobe cycle
    do_op(0, 2'd1, 4'd4, 0, 4'h0, 16'h0AAA, 20'h0, 8'd2, 3, 1, 1);
    chk(got_kind == 3'd2, "R11", "busy start kind", got_kind, 2);
    chk(got_reg == 4'd4, "R11", "busy start reg", got_reg, 4);
    chk(got_add == 20'h00AAA, "R11", "busy start addend", got_add, 20'h00AAA);
    chk(quiet_ok, "R11", "no second decode", quiet_ok, 1);

    // R12 reset in the middle of a fetch
    @(negedge clk);
    start = 1; is_dst = 0; mode = 2'd1; reg_num = 4'd6;
    @(negedge clk);
    start = 0;
    chk(fetch_req == 1, "R8", "fetch raised before reset", fetch_req, 1);
    rst_n = 0;
    #1;
    chk(fetch_req == 0, "R12", "fetch cleared by reset", fetch_req, 0);
    chk(op_valid == 0, "R12", "valid cleared by reset", op_valid, 0);
    @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk(!fetch_req && !op_valid, "R12", "idle after reset", {fetch_req, op_valid}, 0);

    finish_run();
  end

endmodule